// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block models an 18-bit, two-port bus transceiver inside a synchronous core. Data moves from port A to port B and from port B to port A through two independent storage cells. Each cell has its own latch enable, direction clock and output enable. Depending on those levels, a cell passes its input straight through, keeps what it already holds, or loads a new value on a rising edge of its direction clock.

Tristate pins cannot be built inside a core, so each port is split into three parts:
- a data input;
- a per-bit "driven" mask that says which input bits some external agent is actively driving;
- a data output with a single drive-enable.

With the bus-keeper option enabled, an input bit whose mask bit is low reads as the last value it carried while driven. A floating line therefore never reaches the storage cell or the output.

The latch enables, direction clocks and output enables are level inputs sampled by the system clock `clk`. A direction clock "rising edge" means the level is high in this `clk` cycle and was low in the previous one. Reset is synchronous and active high.

Top module: `duplex_reg_xcvr`

## Requirements
- R1: While `rst` is high, both `b_drive` and `a_drive` are low, and both storage cells are cleared to zero. After reset, with the latch enable low and no direction-clock rising edge, each enabled output reads zero.
- R2: With `ab_le` high, `b_dout` equals the effective A input in the same cycle, and the A-to-B cell loads that value at every `clk` edge.
- R3: With `ab_le` low and `ab_ck` at the same level as in the previous cycle, the A-to-B cell keeps its value and changes on `a_din` do not reach `b_dout`.
- R4: With `ab_le` low, a rising edge on `ab_ck` loads the effective A input of that cycle, and `b_dout` shows it from the next cycle on. A falling edge on `ab_ck` leaves the cell unchanged.
- R5: When `ab_le` goes from high to low, the cell keeps the value present in the last cycle `ab_le` was high. If `ab_le` falls in the same cycle as an `ab_ck` rising edge, that cycle's input is loaded instead.
- R6: Outside reset, `b_drive` equals `ab_oe` (active high) and `a_drive` equals the inverse of `ba_oe_n` (active low). Both cells keep updating while their outputs are disabled.
- R7: The B-to-A direction follows R2 to R5, using `ba_le`, `ba_ck`, `b_din` and `a_dout`.
- R8: With `HOLD_EN` = 1, an input bit whose driven-mask bit is 0 reads as the last value it had while its mask bit was 1, or as 0 if it has not been driven since reset. This applies on both ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_din | input | W | Data arriving on port A |
| a_drv_mask | input | W | Per-bit: 1 = A line actively driven, 0 = floating |
| b_din | input | W | Data arriving on port B |
| b_drv_mask | input | W | Per-bit: 1 = B line actively driven, 0 = floating |
| ab_le | input | 1 | A-to-B latch enable, high = pass-through |
| ab_ck | input | 1 | A-to-B direction clock level |
| ab_oe | input | 1 | B port output enable, active high |
| ba_le | input | 1 | B-to-A latch enable, high = pass-through |
| ba_ck | input | 1 | B-to-A direction clock level |
| ba_oe_n | input | 1 | A port output enable, active low |
| b_dout | output | W | Data driven onto port B |
| b_drive | output | 1 | Drive enable for port B |
| a_dout | output | W | Data driven onto port A |
| a_drive | output | 1 | Drive enable for port A |

## Verification
The bench builds the block with `W` = 18 and `HOLD_EN` = 1, so the full data width and the bus-keeper path are both present. At these values, partial driven masks can be applied on both ports, and the retained bits can be seen mixing with freshly driven ones. The same instance also covers the corner cases in both directions:
- a latch enable falling in the same cycle as a direction-clock rise;
- a falling direction-clock edge, which must change nothing;
- cells updated while their output is disabled.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Action a storage cell takes in the current clk cycle.
  typedef enum logic [1:0] {
    CELL_FOLLOW = 2'd0,  // latch enable high: pass and load
    CELL_KEEP   = 2'd1,  // latch enable low, no rising edge: hold
    CELL_SNAP   = 2'd2   // latch enable low, rising direction clock: load
  } cell_act_e;

  localparam int NUM_DIRS = 2;
  localparam int DIR_AB   = 0;
  localparam int DIR_BA   = 1;

endpackage

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int W       = 18,
  parameter bit HOLD_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic [W-1:0] drv,
  output logic [W-1:0] eff
);

  generate
    if (HOLD_EN) begin : g_hold
      logic [W-1:0] held_q;
      logic         past_rst_q;

      always_ff @(posedge clk) begin
        past_rst_q <= rst;
        if (rst) begin
          held_q <= '0;
        end else begin
          held_q <= (drv & din) | (~drv & held_q);
        end
      end

      assign eff = (drv & din) | (~drv & held_q);

      // R8: a floating bit keeps the value it showed one cycle earlier
      a_r8_float_keeps: assert property (@(posedge clk) disable iff (rst)
        !past_rst_q |-> (((eff ^ $past(eff)) & ~drv) == '0));
    end else begin : g_raw
      logic unused_keeper;
      assign unused_keeper = ^{clk, rst, drv};
      assign eff = din;
    end
  endgenerate

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int W      = 18,
  parameter bit OE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic         ck,
  input  logic         oe,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         drive
);
  import xcvr_pkg::*;

  logic [W-1:0] store_q;
  logic         ck_q;
  cell_act_e    act;

  always_comb begin
    if (le)              act = CELL_FOLLOW;
    else if (ck && !ck_q) act = CELL_SNAP;
    else                 act = CELL_KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      ck_q    <= 1'b0;
    end else begin
      ck_q <= ck;
      if (act != CELL_KEEP) store_q <= din;
    end
  end

  assign dout  = (act == CELL_FOLLOW) ? din : store_q;
  assign drive = !rst && (OE_LOW ? !oe : oe);

  // R1: reset empties the cell
  a_r1_clear: assert property (@(posedge clk)
    rst |=> (store_q == '0));

  // R2: pass-through also loads the cell
  a_r2_follow_load: assert property (@(posedge clk) disable iff (rst)
    le |=> (store_q == $past(din)));

  // R3: no enable and no rising edge keeps the cell unchanged
  a_r3_keep: assert property (@(posedge clk) disable iff (rst)
    (!le && !(ck && !ck_q)) |=> $stable(store_q));

  // R4: a rising direction clock with the enable low loads the input
  a_r4_snap: assert property (@(posedge clk) disable iff (rst)
    (!le && ck && !ck_q) |=> (store_q == $past(din)));

endmodule

// File: rtl/duplex_reg_xcvr.sv
module duplex_reg_xcvr #(
  parameter int W       = 18,
  parameter bit HOLD_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_din,
  input  logic [W-1:0] a_drv_mask,
  input  logic [W-1:0] b_din,
  input  logic [W-1:0] b_drv_mask,
  input  logic         ab_le,
  input  logic         ab_ck,
  input  logic         ab_oe,
  input  logic         ba_le,
  input  logic         ba_ck,
  input  logic         ba_oe_n,
  output logic [W-1:0] b_dout,
  output logic         b_drive,
  output logic [W-1:0] a_dout,
  output logic         a_drive
);
  import xcvr_pkg::*;

  logic [NUM_DIRS-1:0][W-1:0] raw, mask, eff, res;
  logic [NUM_DIRS-1:0]        le, ck, oe, drv;

  assign raw[DIR_AB]  = a_din;
  assign mask[DIR_AB] = a_drv_mask;
  assign le[DIR_AB]   = ab_le;
  assign ck[DIR_AB]   = ab_ck;
  assign oe[DIR_AB]   = ab_oe;

  assign raw[DIR_BA]  = b_din;
  assign mask[DIR_BA] = b_drv_mask;
  assign le[DIR_BA]   = ba_le;
  assign ck[DIR_BA]   = ba_ck;
  assign oe[DIR_BA]   = ba_oe_n;

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    xcvr_keeper #(.W(W), .HOLD_EN(HOLD_EN)) u_keep (
      .clk (clk),
      .rst (rst),
      .din (raw[d]),
      .drv (mask[d]),
      .eff (eff[d])
    );

    xcvr_lane #(.W(W), .OE_LOW(d == DIR_BA)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .le    (le[d]),
      .ck    (ck[d]),
      .oe    (oe[d]),
      .din   (eff[d]),
      .dout  (res[d]),
      .drive (drv[d])
    );
  end

  assign b_dout  = res[DIR_AB];
  assign b_drive = drv[DIR_AB];
  assign a_dout  = res[DIR_BA];
  assign a_drive = drv[DIR_BA];

  // R6: output enable polarity outside reset
  a_r6_oe_polarity: assert property (@(posedge clk) disable iff (rst)
    (b_drive == ab_oe) && (a_drive == !ba_oe_n));

endmodule

// File: tb/sim_duplex_reg_xcvr.sv
module sim_duplex_reg_xcvr;
  localparam int W = 18;

  typedef struct {
    logic         bdrv;
    logic [W-1:0] bout;
    logic         adrv;
    logic [W-1:0] aout;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // DUT-connected inputs
  logic         rst = 1'b1;
  logic [W-1:0] a_din = '0, b_din = '0;
  logic [W-1:0] a_drv_mask = '1, b_drv_mask = '1;
  logic         ab_le = 0, ab_ck = 0, ab_oe = 0, ba_le = 0, ba_ck = 0, ba_oe_n = 1;
  logic [W-1:0] b_dout, a_dout;
  logic         b_drive, a_drive;

  // staged next values
  logic         n_rst = 1'b1;
  logic [W-1:0] n_a = '0, n_b = '0, n_am = '1, n_bm = '1;
  logic         n_ab_le = 0, n_ab_ck = 0, n_ab_oe = 0;
  logic         n_ba_le = 0, n_ba_ck = 0, n_ba_oe_n = 1;

  // reference model state
  logic [W-1:0] m_store [2];
  logic         m_ckq   [2];
  logic [W-1:0] m_hold  [2];

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  duplex_reg_xcvr #(.W(W), .HOLD_EN(1'b1)) u0 (
    .clk(clk), .rst(rst),
    .a_din(a_din), .a_drv_mask(a_drv_mask),
    .b_din(b_din), .b_drv_mask(b_drv_mask),
    .ab_le(ab_le), .ab_ck(ab_ck), .ab_oe(ab_oe),
    .ba_le(ba_le), .ba_ck(ba_ck), .ba_oe_n(ba_oe_n),
    .b_dout(b_dout), .b_drive(b_drive),
    .a_dout(a_dout), .a_drive(a_drive)
  );

  function automatic logic [W-1:0] pat(int i);
    return W'(((32'(i) + 1) * 32'h9E37) ^ (32'(i) << 7));
  endfunction

  // Driver: apply staged inputs after a falling edge, predict, push.
  task automatic apply(string tag);
    exp_t e;
    logic [W-1:0] effv [2];
    logic         lev  [2];
    logic         ckv  [2];
    @(negedge clk);
    rst = n_rst; a_din = n_a; b_din = n_b; a_drv_mask = n_am; b_drv_mask = n_bm;
    ab_le = n_ab_le; ab_ck = n_ab_ck; ab_oe = n_ab_oe;
    ba_le = n_ba_le; ba_ck = n_ba_ck; ba_oe_n = n_ba_oe_n;
    effv[0] = (n_am & n_a) | (~n_am & m_hold[0]);
    effv[1] = (n_bm & n_b) | (~n_bm & m_hold[1]);
    lev[0] = n_ab_le; lev[1] = n_ba_le;
    ckv[0] = n_ab_ck; ckv[1] = n_ba_ck;
    e.tag  = tag;
    e.bdrv = !n_rst && n_ab_oe;
    e.adrv = !n_rst && !n_ba_oe_n;
    e.bout = lev[0] ? effv[0] : m_store[0];
    e.aout = lev[1] ? effv[1] : m_store[1];
    q.push_back(e);
    for (int d = 0; d < 2; d++) begin
      if (n_rst) begin
        m_store[d] = '0; m_ckq[d] = 1'b0; m_hold[d] = '0;
      end else begin
        if (lev[d] || (ckv[d] && !m_ckq[d])) m_store[d] = effv[d];
        m_ckq[d]  = ckv[d];
        m_hold[d] = effv[d];
      end
    end
  endtask

  // Monitor: compare between edges.
  always @(negedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (b_drive !== e.bdrv || a_drive !== e.adrv ||
          (e.bdrv && b_dout !== e.bout) || (e.adrv && a_dout !== e.aout)) begin
        n_bad++;
        $display("FAIL %s: got bdrv=%b b=%h adrv=%b a=%h, expected bdrv=%b b=%h adrv=%b a=%h",
                 e.tag, b_drive, b_dout, a_drive, a_dout, e.bdrv, e.bout, e.adrv, e.aout);
      end
    end
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      m_store[d] = '0; m_ckq[d] = 1'b0; m_hold[d] = '0;
    end
    // R1: reset with enables requested: drives must stay low
    n_ab_oe = 1; n_ba_oe_n = 0; n_a = pat(1); n_b = pat(2);
    repeat (3) apply("R1");
    n_rst = 0;
    apply("R1");
    apply("R1");
    // R2: pass-through A to B
    n_ab_le = 1;
    for (int i = 0; i < 5; i++) begin n_a = pat(i + 3); apply("R2"); end
    // R5: enable falls, value from last high cycle kept
    n_ab_le = 0; n_a = pat(9); apply("R5");
    // R3: steady low clock, input changes ignored
    for (int i = 0; i < 3; i++) begin n_a = pat(10 + i); apply("R3"); end
    // R4: rising edge loads, steady high holds, falling edge holds
    n_ab_ck = 1; n_a = pat(20); apply("R4");
    n_a = pat(21); apply("R4");
    n_ab_ck = 0; n_a = pat(22); apply("R4");
    n_a = pat(23); apply("R3");
    // R5: enable falls with a simultaneous rising edge
    n_ab_le = 1; n_a = pat(30); apply("R5");
    n_ab_le = 0; n_ab_ck = 1; n_a = pat(31); apply("R5");
    n_a = pat(32); apply("R5");
    n_ab_ck = 0; apply("R5");
    // R6: disabled output keeps updating storage
    n_ab_oe = 0; n_ab_le = 1; n_a = pat(40); apply("R6");
    n_ab_le = 0; n_a = pat(41); apply("R6");
    n_ab_oe = 1; apply("R6");
    n_ba_oe_n = 1; n_ba_le = 1; n_b = pat(42); apply("R6");
    n_ba_le = 0; n_b = pat(43); apply("R6");
    n_ba_oe_n = 0; apply("R6");
    // R7: B to A pass, hold, edge, fall, simultaneous
    n_ba_le = 1;
    for (int i = 0; i < 3; i++) begin n_b = pat(50 + i); apply("R7"); end
    n_ba_le = 0; n_b = pat(55); apply("R7");
    n_b = pat(56); apply("R7");
    n_ba_ck = 1; n_b = pat(57); apply("R7");
    n_b = pat(58); apply("R7");
    n_ba_ck = 0; n_b = pat(59); apply("R7");
    n_ba_le = 1; n_b = pat(60); apply("R7");
    n_ba_le = 0; n_ba_ck = 1; n_b = pat(61); apply("R7");
    n_b = pat(62); apply("R7");
    n_ba_ck = 0;
    // R8: bus keeper on A, partial then full release
    n_ab_le = 1; n_a = pat(70); apply("R8");
    n_am = 18'h0FF00; n_a = pat(71); apply("R8");
    n_a = pat(72); apply("R8");
    n_am = '0; n_a = pat(73); apply("R8");
    n_a = ~pat(73); apply("R8");
    n_ab_ck = 1; n_ab_le = 0; apply("R8");
    n_am = '1; n_ab_le = 1; n_a = pat(74); apply("R8");
    // R8: bus keeper on B
    n_ba_le = 1; n_b = pat(80); apply("R8");
    n_bm = 18'h3000F; n_b = pat(81); apply("R8");
    n_bm = '0; n_b = pat(82); apply("R8");
    n_b = pat(83); apply("R8");
    // R1: second reset mid-run
    n_rst = 1; apply("R1");
    n_rst = 0; n_ab_le = 0; n_ba_le = 0; n_ab_ck = 0; n_ba_ck = 0; n_bm = '1;
    apply("R1");
    repeat (2) @(negedge clk);
    #8;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no finish, expected finish within 5000 cycles");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule